// File: doc/BRIEF.md
# Heap Stack-Frame Call/Return Controller

This block manages activation frames that live in a pool instead of a contiguous stack. Frames that are not in use are threaded into a singly linked free list through their link word. A call takes the frame at the head of that list, records the suspended frame as its caller, and makes it current. A return hands the current frame back to the head of the list and resumes the frame named by the caller-link register. Only one caller-link register exists. It always describes the current, shallowest frame. When a call goes deeper, its value is stored into the suspended frame's header, and a return reloads it from the header of the frame being resumed.

Returns are not always simple, because frames can be shared. The first case is a frame whose slow-return flag is set, which means its access link differs from its caller link. A return from such a frame is not carried out and is handed to an unimplemented-function handler. The second case is a resumed frame that carries the trap-on-entry flag or has a use count above one. The return completes, and an entry trap is raised before that frame runs. An exhausted pool gives a no-free-frames trap. Each trap is held until it is acknowledged. With every completed operation the block reports whether the program counter should step past the instruction or stay on it.

A header port gives word-level read and write access to every frame. Trap handlers use it to fix up flags and use counts, and the surrounding logic uses it to inspect frames.

Top module: `heap_frame_ctl`

## Requirements
- R1: After reset the current frame is 0, the free-list head is 1, the caller-link register is the null pointer (all ones, 5'd31 by default), and word 0 (next link) of frame f holds f+1 for f = 1..N-2, and the null pointer for f = N-1.
- R2: A call with a non-empty list makes the head frame current. The head then advances to that frame's next link. The new frame gets word 3 (caller link) equal to the old current frame and word 1 equal to 1, which is a use count of 1 with all flags clear. The suspended frame's word 3 receives the old caller-link register value. pcAdvance is 1.
- R3: A call while the free-list head is null raises trap kind 1 (no free frame) with pcAdvance 0, and leaves the current frame and the head unchanged.
- R4: An ordinary return writes the old head into the returning frame's word 0, makes that frame the new head, and makes the caller-link frame current. pcAdvance is 1.
- R5: A return raises trap kind 2 (slow return) with pcAdvance 1 and changes no frame or pointer state in two cases: when the current frame's word 1 has bit 31-1=30 (slow flag) set, or when the caller link is null (return from the root).
- R6: When the frame being resumed has word 1 bit 31 (trap on entry) set or a use count (word 1 bits 7:0) above 1, the return completes and trap kind 3 (entry) is raised with pcAdvance 0. Other flag bits have no effect.
- R7: busy rises on the clock edge that accepts a request and stays high until the operation completes without a trap, or until its trap is acknowledged. Requests are ignored while busy is high.
- R8: trapValid and trapKind hold until trapAck. With no trap pending, trapKind is 0.
- R9: opDone is a one-cycle pulse, asserted one clock after the edge that accepted the request. pcAdvance and the trap outputs are valid with it.
- R10: A header write takes effect on the next clock edge. hdrRdata combinationally shows the addressed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| callReq | input | 1 | Call request strobe |
| retReq | input | 1 | Return request strobe |
| trapAck | input | 1 | Acknowledges a pending trap |
| hdrWe | input | 1 | Header word write enable |
| hdrFrame | input | 4 | Frame index for header access |
| hdrWord | input | 3 | Word index within the frame header |
| hdrWdata | input | 32 | Header write data |
| hdrRdata | output | 32 | Addressed header word |
| busy | output | 1 | Operation or trap pending; requests refused |
| opDone | output | 1 | One-cycle completion pulse |
| pcAdvance | output | 1 | Program counter steps past the instruction |
| trapValid | output | 1 | A trap is pending |
| trapKind | output | 2 | 0 none, 1 no free frame, 2 slow return, 3 entry |
| curFrame | output | 5 | Current frame pointer |
| freeHead | output | 5 | Free-list head pointer, all ones when empty |

## Verification
The no-free-frame trap can only be reached from the ports by emptying the whole pool, so the stimulus makes fifteen calls in a row and checks every allocation along the way before the sixteenth call hits the empty list. Entry and slow-return traps depend on header contents in frames several levels down. The bench therefore unwinds that deep chain one frame at a time, and writes the flags or use count through the header port just before the return that meets them. Returning through the root and then calling again shows whether the returns rebuilt the free list in its original ascending order.

// File: rtl/hfc_pkg.sv
`timescale 1ns/1ps
package hfc_pkg;
  typedef enum logic [1:0] {
    TRAP_NONE    = 2'd0,
    TRAP_NOFRAME = 2'd1,
    TRAP_SLOWRET = 2'd2,
    TRAP_ENTRY   = 2'd3
  } trap_e;

  // strobes from control to datapath
  typedef struct packed {
    logic commitCall;
    logic commitRet;
  } ctrlStrobe_t;

  // conditions reported by the datapath
  typedef struct packed {
    logic listEmpty;
    logic curSlow;
    logic linkNil;
    logic resumeTrap;
  } dpStatus_t;

  // header word roles
  localparam int W_NEXT  = 0;
  localparam int W_HDR   = 1;
  localparam int W_ALINK = 2;
  localparam int W_CLINK = 3;
  localparam int USE_W   = 8;
endpackage

// File: rtl/hfc_frame_dp.sv
`timescale 1ns/1ps
module hfc_frame_dp
  import hfc_pkg::*;
#(
  parameter int NFRAMES   = 16,
  parameter int HDR_WORDS = 8,
  parameter int DATA_W    = 32,
  localparam int FIDX_W   = $clog2(NFRAMES),
  localparam int PW       = FIDX_W + 1,
  localparam int WSEL_W   = $clog2(HDR_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              hdrWe,
  input  logic [FIDX_W-1:0] hdrFrame,
  input  logic [WSEL_W-1:0] hdrWord,
  input  logic [DATA_W-1:0] hdrWdata,
  output logic [DATA_W-1:0] hdrRdata,
  output dpStatus_t         status,
  output logic [PW-1:0]     curFrame,
  output logic [PW-1:0]     freeHead
);
  localparam logic [PW-1:0] NIL = '1;
  localparam int FLAG_T = DATA_W - 1;
  localparam int FLAG_S = DATA_W - 2;

  logic [DATA_W-1:0] mem [NFRAMES][HDR_WORDS];
  logic [PW-1:0] curR, headR, linkR;
  logic [FIDX_W-1:0] curIdx, headIdx, linkIdx;
  logic [DATA_W-1:0] curHdr, linkHdr;

  function automatic logic [DATA_W-1:0] toWord(input logic [PW-1:0] p);
    return {{(DATA_W-PW){1'b0}}, p};
  endfunction

  assign curIdx  = curR[FIDX_W-1:0];
  assign headIdx = headR[FIDX_W-1:0];
  assign linkIdx = linkR[FIDX_W-1:0];
  assign curHdr  = mem[curIdx][W_HDR];
  assign linkHdr = mem[linkIdx][W_HDR];

  assign status.listEmpty  = (headR == NIL);
  assign status.linkNil    = (linkR == NIL);
  assign status.curSlow    = curHdr[FLAG_S];
  assign status.resumeTrap = (linkR != NIL) &&
                             (linkHdr[FLAG_T] || (linkHdr[USE_W-1:0] > USE_W'(1)));

  assign hdrRdata = mem[hdrFrame][hdrWord];
  assign curFrame = curR;
  assign freeHead = headR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int f = 0; f < NFRAMES; f++) begin
        for (int w = 0; w < HDR_WORDS; w++) begin
          if (w == W_NEXT)
            mem[f][w] <= toWord((f == NFRAMES-1) ? NIL : PW'(f + 1));
          else
            mem[f][w] <= '0;
        end
      end
      curR  <= '0;
      headR <= PW'(1);
      linkR <= NIL;
    end else begin
      if (hdrWe) mem[hdrFrame][hdrWord] <= hdrWdata;
      if (strobe.commitCall) begin
        // suspend caller: dump its caller link, then build the callee header
        mem[curIdx][W_CLINK]   <= toWord(linkR);
        mem[headIdx][W_CLINK]  <= toWord(curR);
        mem[headIdx][W_ALINK]  <= toWord(curR);
        mem[headIdx][W_HDR]    <= DATA_W'(1);
        headR <= mem[headIdx][W_NEXT][PW-1:0];
        linkR <= curR;
        curR  <= headR;
      end
      if (strobe.commitRet) begin
        mem[curIdx][W_NEXT] <= toWord(headR);
        headR <= curR;
        curR  <= linkR;
        linkR <= mem[linkIdx][W_CLINK][PW-1:0];
      end
    end
  end
endmodule

// File: rtl/hfc_ctrl.sv
`timescale 1ns/1ps
module hfc_ctrl
  import hfc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        callReq,
  input  logic        retReq,
  input  logic        trapAck,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        opDone,
  output logic        pcAdvance,
  output logic        trapValid,
  output logic [1:0]  trapKind
);
  typedef enum logic [1:0] {S_IDLE, S_EXEC, S_TRAP} state_e;

  state_e stateR;
  logic   opIsCall;
  trap_e  kindR;

  assign strobe.commitCall = (stateR == S_EXEC) && opIsCall && !status.listEmpty;
  assign strobe.commitRet  = (stateR == S_EXEC) && !opIsCall &&
                             !status.linkNil && !status.curSlow;
  assign busy     = (stateR != S_IDLE);
  assign trapKind = kindR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateR    <= S_IDLE;
      opIsCall  <= 1'b0;
      opDone    <= 1'b0;
      pcAdvance <= 1'b0;
      trapValid <= 1'b0;
      kindR     <= TRAP_NONE;
    end else begin
      opDone <= 1'b0;
      case (stateR)
        S_IDLE: begin
          if (callReq || retReq) begin
            opIsCall <= callReq;
            stateR   <= S_EXEC;
          end
        end
        S_EXEC: begin
          opDone <= 1'b1;
          if (opIsCall) begin
            if (status.listEmpty) begin
              pcAdvance <= 1'b0;
              trapValid <= 1'b1;
              kindR     <= TRAP_NOFRAME;
              stateR    <= S_TRAP;
            end else begin
              pcAdvance <= 1'b1;
              stateR    <= S_IDLE;
            end
          end else if (status.linkNil || status.curSlow) begin
            pcAdvance <= 1'b1;
            trapValid <= 1'b1;
            kindR     <= TRAP_SLOWRET;
            stateR    <= S_TRAP;
          end else if (status.resumeTrap) begin
            pcAdvance <= 1'b0;
            trapValid <= 1'b1;
            kindR     <= TRAP_ENTRY;
            stateR    <= S_TRAP;
          end else begin
            pcAdvance <= 1'b1;
            stateR    <= S_IDLE;
          end
        end
        S_TRAP: begin
          if (trapAck) begin
            trapValid <= 1'b0;
            kindR     <= TRAP_NONE;
            stateR    <= S_IDLE;
          end
        end
        default: stateR <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/heap_frame_ctl.sv
`timescale 1ns/1ps
module heap_frame_ctl
  import hfc_pkg::*;
#(
  parameter int NFRAMES   = 16,
  parameter int HDR_WORDS = 8,
  parameter int DATA_W    = 32,
  localparam int FIDX_W   = $clog2(NFRAMES),
  localparam int PW       = FIDX_W + 1,
  localparam int WSEL_W   = $clog2(HDR_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              callReq,
  input  logic              retReq,
  input  logic              trapAck,
  input  logic              hdrWe,
  input  logic [FIDX_W-1:0] hdrFrame,
  input  logic [WSEL_W-1:0] hdrWord,
  input  logic [DATA_W-1:0] hdrWdata,
  output logic [DATA_W-1:0] hdrRdata,
  output logic              busy,
  output logic              opDone,
  output logic              pcAdvance,
  output logic              trapValid,
  output logic [1:0]        trapKind,
  output logic [PW-1:0]     curFrame,
  output logic [PW-1:0]     freeHead
);
  ctrlStrobe_t strobe;
  dpStatus_t   status;

  hfc_ctrl u_ctrl (
    .clk, .rstN, .callReq, .retReq, .trapAck,
    .status, .strobe, .busy, .opDone, .pcAdvance, .trapValid, .trapKind
  );

  hfc_frame_dp #(.NFRAMES(NFRAMES), .HDR_WORDS(HDR_WORDS), .DATA_W(DATA_W)) u_dp (
    .clk, .rstN, .strobe, .hdrWe, .hdrFrame, .hdrWord, .hdrWdata,
    .hdrRdata, .status, .curFrame, .freeHead
  );
endmodule

// File: rtl/hfc_checker.sv
`timescale 1ns/1ps
module hfc_checker
  import hfc_pkg::*;
#(
  parameter int PW = 5
) (
  input logic          clk,
  input logic          rstN,
  input logic          callReq,
  input logic          retReq,
  input logic          trapAck,
  input logic          busy,
  input logic          opDone,
  input logic          pcAdvance,
  input logic          trapValid,
  input logic [1:0]    trapKind,
  input logic [PW-1:0] curFrame,
  input logic [PW-1:0] freeHead
);
  a_r7_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && (callReq || retReq)) |=> busy);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    opDone |=> !opDone);

  a_r8_trap_hold: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid && !trapAck) |=> (trapValid && $stable(trapKind)));

  a_r8_kind_idle: assert property (@(posedge clk) disable iff (!rstN)
    !trapValid |-> (trapKind == TRAP_NONE));

  a_r3_noframe_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (opDone && trapKind == TRAP_NOFRAME) |->
      ($stable(curFrame) && $stable(freeHead) && !pcAdvance));

  a_r5_slow_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (opDone && trapKind == TRAP_SLOWRET) |->
      ($stable(curFrame) && $stable(freeHead) && pcAdvance));

  a_r6_entry_moves: assert property (@(posedge clk) disable iff (!rstN)
    (opDone && trapKind == TRAP_ENTRY) |-> (!pcAdvance && !$stable(curFrame)));
endmodule

bind heap_frame_ctl hfc_checker #(.PW(PW)) u_chk (
  .clk(clk), .rstN(rstN), .callReq(callReq), .retReq(retReq), .trapAck(trapAck),
  .busy(busy), .opDone(opDone), .pcAdvance(pcAdvance), .trapValid(trapValid),
  .trapKind(trapKind), .curFrame(curFrame), .freeHead(freeHead)
);

// File: tb/heap_frame_ctl_tb.sv
`timescale 1ns/1ps
module heap_frame_ctl_tb;
  localparam int N   = 16;
  localparam int NIL = 31;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        callReq = 1'b0, retReq = 1'b0, trapAck = 1'b0, hdrWe = 1'b0;
  logic [3:0]  hdrFrame = '0;
  logic [2:0]  hdrWord = '0;
  logic [31:0] hdrWdata = '0;
  logic [31:0] hdrRdata;
  logic        busy, opDone, pcAdvance, trapValid;
  logic [1:0]  trapKind;
  logic [4:0]  curFrame, freeHead;

  int checks = 0;
  int fails  = 0;

  heap_frame_ctl u_dut (
    .clk, .rstN, .callReq, .retReq, .trapAck, .hdrWe, .hdrFrame, .hdrWord,
    .hdrWdata, .hdrRdata, .busy, .opDone, .pcAdvance, .trapValid, .trapKind,
    .curFrame, .freeHead
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic doOp(input bit isCall);
    @(negedge clk);
    callReq = isCall;
    retReq  = !isCall;
    @(negedge clk);
    callReq = 1'b0;
    retReq  = 1'b0;
    @(negedge clk);
    chk("R9 opDone pulse", int'(opDone), 1);
  endtask

  task automatic ackTrap();
    @(negedge clk);
    trapAck = 1'b1;
    @(negedge clk);
    trapAck = 1'b0;
    chk("R8 trap cleared by ack", int'(trapValid), 0);
    chk("R8 kind none after ack", int'(trapKind), 0);
    chk("R7 busy low after ack", int'(busy), 0);
  endtask

  task automatic wrHdr(input int f, input int w, input logic [31:0] d);
    @(negedge clk);
    hdrWe = 1'b1; hdrFrame = 4'(f); hdrWord = 3'(w); hdrWdata = d;
    @(negedge clk);
    hdrWe = 1'b0;
  endtask

  task automatic rdHdr(input int f, input int w, output logic [31:0] d);
    hdrFrame = 4'(f); hdrWord = 3'(w);
    #1;
    d = hdrRdata;
  endtask

  task automatic step(input string tag, input int eCur, input int eHead,
                      input int eTrap, input int eKind, input int eAdv);
    chk({tag, " curFrame"}, int'(curFrame), eCur);
    chk({tag, " freeHead"}, int'(freeHead), eHead);
    chk({tag, " trapValid"}, int'(trapValid), eTrap);
    chk({tag, " trapKind"}, int'(trapKind), eKind);
    chk({tag, " pcAdvance"}, int'(pcAdvance), eAdv);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state and free chain
    chk("R1 cur after reset", int'(curFrame), 0);
    chk("R1 head after reset", int'(freeHead), 1);
    chk("R7 busy after reset", int'(busy), 0);
    chk("R8 no trap after reset", int'(trapValid), 0);
    for (int f = 1; f < N; f++) begin
      rdHdr(f, 0, d);
      chk("R1 initial next link", int'(d), (f == N-1) ? NIL : f + 1);
    end

    // R2 fill the pool
    for (int k = 1; k < N; k++) begin
      doOp(1'b1);
      step("R2 call", k, (k == N-1) ? NIL : k + 1, 0, 0, 1);
      rdHdr(k, 3, d);
      chk("R2 callee caller link", int'(d), k - 1);
      rdHdr(k, 1, d);
      chk("R2 callee header word", int'(d), 1);
      rdHdr(k - 1, 3, d);
      chk("R2 caller link dumped", int'(d), (k == 1) ? NIL : k - 2);
    end

    // R3 empty pool
    doOp(1'b1);
    step("R3 no free frame", N-1, NIL, 1, 1, 0);
    chk("R7 busy during trap", int'(busy), 1);
    // R7 request refused while trap pending
    @(negedge clk); retReq = 1'b1;
    @(negedge clk); retReq = 1'b0;
    @(negedge clk);
    chk("R7 refused return keeps cur", int'(curFrame), N-1);
    chk("R7 refused return no done", int'(opDone), 0);
    chk("R8 trap held", int'(trapKind), 1);
    ackTrap();

    // R4 ordinary return
    doOp(1'b0);
    step("R4 return", 14, 15, 0, 0, 1);
    rdHdr(15, 0, d);
    chk("R4 freed frame next", int'(d), NIL);

    // R5 slow flag, R10 header write
    wrHdr(14, 1, 32'h4000_0001);
    rdHdr(14, 1, d);
    chk("R10 header readback", int'(d), 32'h4000_0001);
    doOp(1'b0);
    step("R5 slow return", 14, 15, 1, 2, 1);
    ackTrap();
    wrHdr(14, 1, 32'h0000_0001);

    // R6 trap-on-entry flag on resumed frame
    wrHdr(12, 1, 32'h8000_0001);
    doOp(1'b0);
    step("R6 plain return", 13, 14, 0, 0, 1);
    doOp(1'b0);
    step("R6 entry trap flag", 12, 13, 1, 3, 0);
    ackTrap();
    wrHdr(12, 1, 32'h0000_0001);

    // R6 shared frame via use count
    wrHdr(11, 1, 32'h0000_0002);
    doOp(1'b0);
    step("R6 entry trap usecount", 11, 12, 1, 3, 0);
    ackTrap();

    // R6 other flags ignored
    wrHdr(10, 1, 32'h3F00_0001);
    doOp(1'b0);
    step("R6 other flags ignored", 10, 11, 0, 0, 1);

    // R4 unwind to root
    for (int k = 10; k >= 1; k--) begin
      doOp(1'b0);
      step("R4 unwind", k - 1, k, 0, 0, 1);
    end
    for (int f = 1; f < N; f++) begin
      rdHdr(f, 0, d);
      chk("R4 relinked chain", int'(d), (f == N-1) ? NIL : f + 1);
    end

    // R5 return from root
    doOp(1'b0);
    step("R5 root return", 0, 1, 1, 2, 1);
    ackTrap();

    // R2 allocation after relink
    doOp(1'b1);
    step("R2 call after unwind", 1, 2, 0, 0, 1);

    summary();
    $finish;
  end
endmodule